// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This bridge lets a processor reach a conventional ATA task-file register set through an ordinary byte-addressed memory-mapped bus. It decodes a 4 KiB window and places one register in each 16-byte slot. Byte accesses reach the seven task-file registers and the control register. The control register can be reached through two separate slots. Halfword and word accesses reach only the data port. Their bytes are reversed in both directions, so a host with one byte order can talk to a device that uses the other.

Every request is accepted in the cycle it is presented. A mapped request produces exactly one read or write strobe towards the device in the next cycle. A read is answered in that same cycle. A request to a slot that has no register at its width is dropped without any device activity, and a read of such a slot returns all ones.

Top module: `mmio_ata_bridge`

## Requirements
- R1: Only address bits [11:4] select the slot. Bits above 11 and bits [3:0] have no effect on the decode.
- R2: A byte access (size 0) to slots 1 to 7 selects the task-file chip select and puts the slot number on `dev_addr`. A byte write drives `{24'h0, wdata[7:0]}`. A byte read returns `{24'h0, dev_rdata[7:0]}`.
- R3: A byte access to slot 8 or slot 22 selects the control chip select with `dev_addr` = 6. A write sets device control. A read returns the alternate status in the low byte.
- R4: A byte access to any other slot, including slot 0, makes no strobe. A byte read there returns `32'h0000_00FF`.
- R5: A halfword access (size 1) to slot 0 selects the task-file chip select with `dev_addr` = 0. The two bytes are swapped. A write drives `{16'h0, wdata[7:0], wdata[15:8]}`. A read returns `{16'h0, dev_rdata[7:0], dev_rdata[15:8]}`.
- R6: A word access (size 2) to slot 0 reverses all four bytes in both directions. Bus byte 0 travels on device byte 3.
- R7: A halfword or word access to any slot other than 0 makes no strobe. Reads there return `32'h0000_FFFF` (halfword) or `32'hFFFF_FFFF` (word). Size 3 is reserved: it never strobes, and a size-3 read returns `32'hFFFF_FFFF`.
- R8: `bus_ready` is high whenever reset is low. Each accepted read raises `rsp_valid` for exactly the next cycle, with `rsp_rdata` valid in that cycle. Writes raise no response.
- R9: Each mapped access produces exactly one strobe (`dev_rd` or `dev_wr`), one cycle after acceptance, with exactly one chip select high.
- R10: A synchronous reset clears any pending response, deasserts both strobes and holds `bus_ready` low. A request presented during reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, bus byte order |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, bus byte order |
| dev_addr | output | 3 | Device register address |
| dev_cs_tf | output | 1 | Task-file / data chip select |
| dev_cs_ctl | output | 1 | Control / alternate-status chip select |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 32 | Write data, device byte order |
| dev_rdata | input | 32 | Read data from the device, valid while `dev_rd` is high |

## Verification
The bench applies byte, halfword, word and reserved-size requests to every class of slot: task-file slots, both control aliases, the data port, and unmapped slots. This separates a decode that keys on the slot from one that also keys on the width. Distinct per-byte values in the write data and in the device model's read value expose a missing or wrong-direction swap, and show the halfword and word cases apart. Addresses with junk in the upper bits and in the low nibble test that only the slot bits matter. Back-to-back requests, idle cycles and a request made during reset test that each access gives exactly one strobe and one response.

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge #(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 12,
  parameter int SLOT_BITS  = 4,
  parameter int CTL_SLOT_A = 8,
  parameter int CTL_SLOT_B = 22,
  parameter int CTL_REG    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [2:0]        dev_addr,
  output logic              dev_cs_tf,
  output logic              dev_cs_ctl,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata
);
  localparam int IDX_W = WIN_BITS - SLOT_BITS;

  logic [IDX_W-1:0] idx;
  logic accept, is_tf, is_ctl, is_data, hit;
  logic [31:0] wswap;
  logic [1:0] rsz;
  logic rhit;
  logic unused_addr_bits;

  assign idx = bus_addr[WIN_BITS-1:SLOT_BITS];
  assign unused_addr_bits = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_addr[SLOT_BITS-1:0]};
  assign bus_ready = ~rst;
  assign accept = bus_valid & bus_ready;

  assign is_tf   = (bus_size == 2'd0) && (idx >= IDX_W'(1)) && (idx <= IDX_W'(7));
  assign is_ctl  = (bus_size == 2'd0) &&
                   ((idx == IDX_W'(CTL_SLOT_A)) || (idx == IDX_W'(CTL_SLOT_B)));
  assign is_data = ((bus_size == 2'd1) || (bus_size == 2'd2)) && (idx == '0);
  assign hit     = is_tf | is_ctl | is_data;

  always_comb begin
    case (bus_size)
      2'd0:    wswap = {24'h0, bus_wdata[7:0]};
      2'd1:    wswap = {16'h0, bus_wdata[7:0], bus_wdata[15:8]};
      default: wswap = {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_rd     <= 1'b0;
      dev_wr     <= 1'b0;
      rsp_valid  <= 1'b0;
      dev_cs_tf  <= 1'b0;
      dev_cs_ctl <= 1'b0;
      dev_addr   <= '0;
      dev_wdata  <= '0;
      rsz        <= '0;
      rhit       <= 1'b0;
    end else begin
      dev_rd    <= accept & ~bus_write & hit;
      dev_wr    <= accept &  bus_write & hit;
      rsp_valid <= accept & ~bus_write;
      if (accept) begin
        dev_cs_tf  <= is_tf | is_data;
        dev_cs_ctl <= is_ctl;
        dev_addr   <= is_ctl ? 3'(CTL_REG) : (is_tf ? idx[2:0] : 3'd0);
        dev_wdata  <= wswap;
        rsz        <= bus_size;
        rhit       <= hit;
      end
    end
  end

  always_comb begin
    case (rsz)
      2'd0:    rsp_rdata = rhit ? {24'h0, dev_rdata[7:0]} : 32'h0000_00FF;
      2'd1:    rsp_rdata = rhit ? {16'h0, dev_rdata[7:0], dev_rdata[15:8]} : 32'h0000_FFFF;
      2'd2:    rsp_rdata = rhit ? {dev_rdata[7:0], dev_rdata[15:8], dev_rdata[23:16], dev_rdata[31:24]}
                                : 32'hFFFF_FFFF;
      default: rsp_rdata = 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/mmio_ata_bridge_chk.sv
module mmio_ata_bridge_chk #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              dev_cs_tf,
  input logic              dev_cs_ctl,
  input logic              dev_rd,
  input logic              dev_wr,
  input logic [31:0]       dev_wdata
);
  logic acc, slot0;
  assign acc   = bus_valid && bus_ready;
  assign slot0 = (bus_addr[WIN_BITS-1:4] == '0);

  assert_rsp_next_R8: assert property (@(posedge clk) disable iff (rst)
    acc && !bus_write |=> rsp_valid);

  assert_no_rsp_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    acc && bus_write |=> !rsp_valid);

  assert_single_cs_R9: assert property (@(posedge clk) disable iff (rst)
    (dev_rd || dev_wr) |-> ($countones({dev_cs_tf, dev_cs_ctl}) == 1) && !(dev_rd && dev_wr));

  assert_strobe_has_request_R9: assert property (@(posedge clk) disable iff (rst)
    (dev_rd || dev_wr) |-> $past(bus_valid));

  assert_half_swap_R5: assert property (@(posedge clk) disable iff (rst)
    acc && bus_write && bus_size == 2'd1 && slot0 |=>
      dev_wr && dev_wdata[15:0] == {$past(bus_wdata[7:0]), $past(bus_wdata[15:8])});

  assert_unmapped_word_R7: assert property (@(posedge clk) disable iff (rst)
    acc && !bus_write && bus_size == 2'd2 && !slot0 |=> !dev_rd && rsp_rdata == 32'hFFFF_FFFF);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> !dev_rd && !dev_wr && !rsp_valid);
endmodule

bind mmio_ata_bridge mmio_ata_bridge_chk i_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .dev_cs_tf(dev_cs_tf), .dev_cs_ctl(dev_cs_ctl), .dev_rd(dev_rd),
  .dev_wr(dev_wr), .dev_wdata(dev_wdata)
);

// File: tb/test_mmio_ata_bridge.sv
module test_mmio_ata_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic bus_ready, rsp_valid, dev_cs_tf, dev_cs_ctl, dev_rd, dev_wr;
  logic [31:0] rsp_rdata, dev_wdata, dev_rdata;
  logic [2:0] dev_addr;

  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mmio_ata_bridge i_mmio_ata_bridge (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_addr(dev_addr), .dev_cs_tf(dev_cs_tf), .dev_cs_ctl(dev_cs_ctl),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  function automatic logic [31:0] devval(input logic ctl, input logic [2:0] a);
    if (ctl) return 32'h5C5C_5CE1;
    if (a == 3'd0) return 32'h1122_3344;
    return {24'hA0A0A0, 8'h40 | {5'b0, a}};
  endfunction

  assign dev_rdata = devval(dev_cs_ctl, dev_addr);

  typedef struct {
    bit rd; bit wr; bit ctl; bit [2:0] a; bit [31:0] wd; bit rv; bit [31:0] rdt; string req;
  } item_t;
  item_t q[$];

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      bit ok;
      it = q.pop_front();
      ok = (dev_rd == it.rd) && (dev_wr == it.wr) && (rsp_valid == it.rv);
      if (it.rd || it.wr)
        ok = ok && (dev_cs_ctl == it.ctl) && (dev_cs_tf == !it.ctl) && (dev_addr == it.a);
      if (it.wr) ok = ok && (dev_wdata == it.wd);
      if (it.rv) ok = ok && (rsp_rdata == it.rdt);
      applied++;
      if (!ok) begin
        bad++;
        $display("FAIL %s: actual rd=%0b wr=%0b rv=%0b ctl=%0b tf=%0b a=%0d wd=%h rdata=%h expected rd=%0b wr=%0b rv=%0b ctl=%0b a=%0d wd=%h rdata=%h",
                 it.req, dev_rd, dev_wr, rsp_valid, dev_cs_ctl, dev_cs_tf, dev_addr, dev_wdata,
                 rsp_rdata, it.rd, it.wr, it.rv, it.ctl, it.a, it.wd, it.rdt);
      end
    end
  end

  task automatic acc(input bit wr, input bit [1:0] sz, input bit [31:0] addr,
                     input bit [31:0] wd, input string req);
    item_t it;
    bit [7:0] idx;
    bit hit;
    bit [31:0] dv;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = addr; bus_wdata = wd;
    idx = addr[11:4];
    hit = 1'b0; it.ctl = 1'b0; it.a = 3'd0;
    if (sz == 2'd0 && idx >= 8'd1 && idx <= 8'd7) begin hit = 1'b1; it.a = idx[2:0]; end
    else if (sz == 2'd0 && (idx == 8'd8 || idx == 8'd22)) begin hit = 1'b1; it.ctl = 1'b1; it.a = 3'd6; end
    else if ((sz == 2'd1 || sz == 2'd2) && idx == 8'd0) hit = 1'b1;
    it.rd = hit && !wr;
    it.wr = hit && wr;
    it.rv = !wr;
    case (sz)
      2'd0: it.wd = {24'h0, wd[7:0]};
      2'd1: it.wd = {16'h0, wd[7:0], wd[15:8]};
      default: it.wd = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
    endcase
    dv = devval(it.ctl, it.a);
    case (sz)
      2'd0: it.rdt = hit ? {24'h0, dv[7:0]} : 32'h0000_00FF;
      2'd1: it.rdt = hit ? {16'h0, dv[7:0], dv[15:8]} : 32'h0000_FFFF;
      2'd2: it.rdt = hit ? {dv[7:0], dv[15:8], dv[23:16], dv[31:24]} : 32'hFFFF_FFFF;
      default: it.rdt = 32'hFFFF_FFFF;
    endcase
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input string req);
    item_t it;
    @(negedge clk);
    bus_valid = 1'b0;
    it = '{rd: 0, wr: 0, ctl: 0, a: 0, wd: 0, rv: 0, rdt: 0, req: req};
    q.push_back(it);
  endtask

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dev_rd && !dev_wr && !rsp_valid, "R10", "strobes in reset",
        {29'h0, dev_rd, dev_wr, rsp_valid}, 32'h0);
    chk(bus_ready == 1'b0, "R10", "ready in reset", {31'h0, bus_ready}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_ready == 1'b1, "R8", "ready after reset", {31'h0, bus_ready}, 32'h1);

    for (int i = 1; i <= 7; i++) acc(1, 2'd0, 32'(i << 4), 32'hDEAD_BE00 | 32'(i), "R2");
    acc(0, 2'd0, 32'h0000_0030, 0, "R2");
    acc(0, 2'd0, 32'h0000_0070, 0, "R2");
    acc(0, 2'd0, 32'hABCD_E01C, 0, "R1");
    acc(0, 2'd0, 32'hFFFF_F165, 0, "R1");
    acc(1, 2'd0, 32'h0000_0080, 32'h0000_0002, "R3");
    acc(0, 2'd0, 32'h0000_0160, 0, "R3");
    acc(1, 2'd0, 32'h0000_0168, 32'h0000_0004, "R3");
    acc(0, 2'd0, 32'h0000_008F, 0, "R3");
    acc(0, 2'd0, 32'h0000_0000, 0, "R4");
    acc(1, 2'd0, 32'h0000_0000, 32'h55, "R4");
    acc(0, 2'd0, 32'h0000_0090, 0, "R4");
    acc(0, 2'd0, 32'h0000_0FF0, 0, "R4");
    acc(1, 2'd1, 32'h0000_0000, 32'h1234_BEEF, "R5");
    acc(0, 2'd1, 32'h0000_0002, 0, "R5");
    acc(1, 2'd2, 32'h0000_0008, 32'h0123_4567, "R6");
    acc(0, 2'd2, 32'h7000_0000, 0, "R6");
    idle("R9");
    acc(0, 2'd1, 32'h0000_0010, 0, "R7");
    acc(0, 2'd2, 32'h0000_0080, 0, "R7");
    acc(1, 2'd2, 32'h0000_0030, 32'hCAFE_F00D, "R7");
    acc(1, 2'd1, 32'h0000_0160, 32'hCAFE_F00D, "R7");
    acc(0, 2'd3, 32'h0000_0000, 0, "R7");
    acc(1, 2'd3, 32'h0000_0000, 32'h1, "R7");
    acc(0, 2'd0, 32'h0000_0050, 0, "R8");
    acc(0, 2'd2, 32'h0000_0000, 0, "R8");
    acc(1, 2'd0, 32'h0000_0050, 32'h77, "R8");
    idle("R8");
    idle("R9");

    @(negedge clk);
    rst = 1'b1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_size = 2'd0; bus_addr = 32'h10;
    begin
      item_t it;
      it = '{rd: 0, wr: 0, ctl: 0, a: 0, wd: 0, rv: 0, rdt: 0, req: "R10"};
      q.push_back(it);
    end
    #1 chk(bus_ready == 1'b0, "R10", "ready during reset request", {31'h0, bus_ready}, 32'h0);
    @(negedge clk);
    rst = 1'b0; bus_valid = 1'b0;
    acc(0, 2'd0, 32'h0000_0020, 0, "R10");
    idle("R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule